// File: doc/BRIEF.md
# MESI Snooping Line Coherence Controller

This block holds the coherence state of one line in a private cache on a snooping bus that is atomic and totally ordered. It takes core requests (load, store, replacement), observes every request ordered on the bus, and accepts data responses. From these it issues its own bus requests, supplies data when it owns the line, and tells the core when a load or store has finished. The data array, the tag match and bus arbitration are outside the block. The bus is modelled as one ordered event per cycle, with a source identifier that separates this cache's own requests from those of other caches.

The four stable states are Modified, Exclusive, Shared and Invalid, and nine transient states cover the line's outstanding requests. Thirteen states in all are encoded on `line_state`. A line filled with data marked exclusive can later be written with no bus traffic. A clean exclusive line is evicted with a PutM that ends in a no-data-exclusive message rather than a writeback.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset the line reads Invalid (`line_state` = 0), and `req_valid`, `core_done`, `send_data`, `send_nodata` and `send_nodata_e` are all low.
- R2: A load accepted in Invalid raises `req_valid` with `req_cmd` = 0 (GetS) in the next cycle and moves to IS_AD (4). The line's own GetS (bus_cmd 0 with bus_src equal to CORE_ID) moves it to IS_D (5). A response with `rsp_excl` high then moves it to Exclusive (2), and one with `rsp_excl` low moves it to Shared (1). In both cases `core_done` pulses.
- R3: A store accepted in Exclusive pulses `core_done` in the next cycle and moves the line to Modified (3), with `req_valid` low.
- R4: A replacement accepted in Exclusive issues `req_cmd` = 2 (PutM) and enters EI_A (11). When its own PutM is seen, `send_nodata_e` pulses, `send_data` stays low and the line goes to Invalid.
- R5: A replacement accepted in Modified issues PutM and enters MI_A (10). When its own PutM is seen, `send_data` pulses and the line goes to Invalid.
- R6: In Exclusive or Modified, another cache's GetS (bus_cmd 0) pulses `send_data` and moves the line to Shared. Another cache's GetM (bus_cmd 1) pulses `send_data` and moves it to Invalid. Another cache's PutM (bus_cmd 2) changes nothing.
- R7: In Shared, another cache's GetM moves the line to Invalid without data, another cache's GetS or PutM changes nothing, and a replacement goes to Invalid with no bus request.
- R8: A store accepted in Shared or Invalid issues `req_cmd` = 1 (GetM) and enters SM_AD (8) or IM_AD (6). The line's own GetM moves it to SM_D (9) or IM_D (7). `core_done` pulses only when the data response then moves the line to Modified.
- R9: `core_ready` is low in every transient state (codes 4 to 12) and in any cycle with `bus_valid` or `rsp_valid` high. A core request offered while `core_ready` is low has no effect.
- R10: In MI_A or EI_A, another cache's GetS or GetM pulses `send_data` and moves the line to II_A (12). Its own PutM then pulses `send_nodata` and moves it to Invalid. At most one of the three response outputs is high in any cycle.
- R11: A load in Shared, Exclusive or Modified, and a store in Modified, pulse `core_done` in the next cycle with no bus request and no change of state.
- R12: In SM_AD, another cache's GetM moves the line to IM_AD. The store still completes after the line's own GetM and the data response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core request offered |
| core_op | input | 2 | 0 load, 1 store, 2 replacement |
| core_ready | output | 1 | Core request accepted this cycle |
| core_done | output | 1 | Load or store finished (pulse) |
| bus_valid | input | 1 | An ordered bus request is seen this cycle |
| bus_cmd | input | 2 | 0 GetS, 1 GetM, 2 PutM |
| bus_src | input | SRC_W | Identifier of the requesting cache |
| rsp_valid | input | 1 | Data response for this line's request |
| rsp_excl | input | 1 | Response carries exclusive permission |
| req_valid | output | 1 | Bus request from this line (pulse) |
| req_cmd | output | 2 | 0 GetS, 1 GetM, 2 PutM |
| send_data | output | 1 | Line supplies its data (pulse) |
| send_nodata | output | 1 | Stale PutM resolved with no data (pulse) |
| send_nodata_e | output | 1 | Clean exclusive eviction resolved with no data (pulse) |
| line_state | output | 4 | Current state code |

## Verification
Each stable state is reached through its real request path, with no forced state. Another cache's GetS, GetM and PutM are then applied from every foreign source identifier. This separates the owner's responses from the sharer's silent invalidation, and shows that a PutM from elsewhere does nothing. Evictions from Exclusive and Modified are compared so that the clean no-data ending and the dirty writeback cannot be mistaken for each other. The sequences in which a snoop lands on a pending eviction, or on a pending upgrade from Shared, are what show the II_A and IM_AD detours. Core requests offered during transients and during bus cycles show that stalled requests leave no trace.

// File: rtl/mle_pkg.sv
// Shared types for the MESI line controller.
package mle_pkg;
    typedef enum logic [3:0] {
        ST_I     = 4'd0,
        ST_S     = 4'd1,
        ST_E     = 4'd2,
        ST_M     = 4'd3,
        ST_IS_AD = 4'd4,
        ST_IS_D  = 4'd5,
        ST_IM_AD = 4'd6,
        ST_IM_D  = 4'd7,
        ST_SM_AD = 4'd8,
        ST_SM_D  = 4'd9,
        ST_MI_A  = 4'd10,
        ST_EI_A  = 4'd11,
        ST_II_A  = 4'd12
    } line_st_t;

    localparam logic [1:0] BUS_GETS = 2'd0;
    localparam logic [1:0] BUS_GETM = 2'd1;
    localparam logic [1:0] BUS_PUTM = 2'd2;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_REPL  = 2'd2;

    // Classified bus event, split by requester.
    typedef struct packed {
        logic own_gets;
        logic own_getm;
        logic own_putm;
        logic oth_gets;
        logic oth_getm;
    } snoop_t;

    // Accepted core request, one-hot or empty.
    typedef struct packed {
        logic ld;
        logic st;
        logic rp;
    } core_req_t;

    // Actions produced by one transition.
    typedef struct packed {
        logic       req_v;
        logic [1:0] req_cmd;
        logic       data;
        logic       nodata;
        logic       nodata_e;
        logic       done;
    } act_t;
endpackage

// File: rtl/mle_snoop_decode.sv
// Classifies the ordered bus event as this cache's own request or another
// cache's. Assumes at most one bus event per cycle and that bus_src equal to
// CORE_ID marks this cache. Another cache's PutM never affects this line, so
// it is not decoded.
module mle_snoop_decode
    import mle_pkg::*;
#(
    parameter int SRC_W   = 2,
    parameter int CORE_ID = 0
) (
    input  logic             bus_valid,
    input  logic [1:0]       bus_cmd,
    input  logic [SRC_W-1:0] bus_src,
    output snoop_t           snoop
);
    localparam logic [SRC_W-1:0] OWN_ID = SRC_W'(CORE_ID);

    logic own;
    logic oth;

    // Split the event by requester and by command.
    always_comb begin
        own = bus_valid && (bus_src == OWN_ID);
        oth = bus_valid && (bus_src != OWN_ID);
        snoop.own_gets = own && (bus_cmd == BUS_GETS);
        snoop.own_getm = own && (bus_cmd == BUS_GETM);
        snoop.own_putm = own && (bus_cmd == BUS_PUTM);
        snoop.oth_gets = oth && (bus_cmd == BUS_GETS);
        snoop.oth_getm = oth && (bus_cmd == BUS_GETM);
    end
endmodule

// File: rtl/mle_core_gate.sv
// Accepts a core request only in a stable state and only in a cycle with no
// bus event and no response. Assumes the core holds a refused request and
// offers it again later.
module mle_core_gate
    import mle_pkg::*;
(
    input  logic      core_valid,
    input  logic [1:0] core_op,
    input  line_st_t  state,
    input  logic      bus_valid,
    input  logic      rsp_valid,
    output logic      core_ready,
    output core_req_t req
);
    logic stable;

    // Decide acceptance and decode the accepted operation.
    always_comb begin
        stable     = (state == ST_I) || (state == ST_S) ||
                     (state == ST_E) || (state == ST_M);
        core_ready = stable && !bus_valid && !rsp_valid;
        req.ld     = core_valid && core_ready && (core_op == OP_LOAD);
        req.st     = core_valid && core_ready && (core_op == OP_STORE);
        req.rp     = core_valid && core_ready && (core_op == OP_REPL);
    end
endmodule

// File: rtl/mle_fsm_next.sv
// Transition table of the line: next state and actions from the current
// state, one accepted core request, one classified snoop and one response.
// Assumes the core gate keeps core requests apart from bus and response cycles.
module mle_fsm_next
    import mle_pkg::*;
(
    input  line_st_t  state,
    input  core_req_t req,
    input  snoop_t    snoop,
    input  logic      rsp_valid,
    input  logic      rsp_excl,
    output line_st_t  nxt,
    output act_t      act
);
    // Evaluate the transition for the current event.
    always_comb begin
        nxt = state;
        act = '0;
        unique case (state)
            ST_I: begin
                if (req.ld) begin
                    nxt = ST_IS_AD; act.req_v = 1'b1; act.req_cmd = BUS_GETS;
                end else if (req.st) begin
                    nxt = ST_IM_AD; act.req_v = 1'b1; act.req_cmd = BUS_GETM;
                end
            end
            ST_IS_AD: if (snoop.own_gets) nxt = ST_IS_D;
            ST_IS_D: begin
                if (rsp_valid) begin
                    nxt = rsp_excl ? ST_E : ST_S;
                    act.done = 1'b1;
                end
            end
            ST_IM_AD: if (snoop.own_getm) nxt = ST_IM_D;
            ST_IM_D, ST_SM_D: begin
                if (rsp_valid) begin
                    nxt = ST_M; act.done = 1'b1;
                end
            end
            ST_S: begin
                if (req.ld) begin
                    act.done = 1'b1;
                end else if (req.st) begin
                    nxt = ST_SM_AD; act.req_v = 1'b1; act.req_cmd = BUS_GETM;
                end else if (req.rp || snoop.oth_getm) begin
                    nxt = ST_I;
                end
            end
            ST_SM_AD: begin
                if (snoop.own_getm)      nxt = ST_SM_D;
                else if (snoop.oth_getm) nxt = ST_IM_AD;
            end
            ST_E, ST_M: begin
                if (req.ld) begin
                    act.done = 1'b1;
                end else if (req.st) begin
                    nxt = ST_M; act.done = 1'b1;
                end else if (req.rp) begin
                    nxt = (state == ST_E) ? ST_EI_A : ST_MI_A;
                    act.req_v = 1'b1; act.req_cmd = BUS_PUTM;
                end else if (snoop.oth_gets) begin
                    nxt = ST_S; act.data = 1'b1;
                end else if (snoop.oth_getm) begin
                    nxt = ST_I; act.data = 1'b1;
                end
            end
            ST_MI_A, ST_EI_A: begin
                if (snoop.own_putm) begin
                    nxt = ST_I;
                    if (state == ST_MI_A) act.data = 1'b1;
                    else                  act.nodata_e = 1'b1;
                end else if (snoop.oth_gets || snoop.oth_getm) begin
                    nxt = ST_II_A; act.data = 1'b1;
                end
            end
            ST_II_A: begin
                if (snoop.own_putm) begin
                    nxt = ST_I; act.nodata = 1'b1;
                end
            end
            default: nxt = ST_I;
        endcase
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
// Per-line MESI coherence controller for a private cache on an atomic,
// totally ordered snooping bus. Holds the state register and registers every
// action, so outputs appear in the cycle after the event that caused them.
// Assumes one bus event per cycle and that a response arrives only after the
// line's own request has been ordered.
module mesi_line_ctrl
    import mle_pkg::*;
#(
    parameter int SRC_W   = 2,
    parameter int CORE_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_valid,
    input  logic [1:0]       core_op,
    output logic             core_ready,
    output logic             core_done,
    input  logic             bus_valid,
    input  logic [1:0]       bus_cmd,
    input  logic [SRC_W-1:0] bus_src,
    input  logic             rsp_valid,
    input  logic             rsp_excl,
    output logic             req_valid,
    output logic [1:0]       req_cmd,
    output logic             send_data,
    output logic             send_nodata,
    output logic             send_nodata_e,
    output logic [3:0]       line_state
);
    line_st_t  state_q;
    line_st_t  state_d;
    snoop_t    snoop;
    core_req_t creq;
    act_t      act_d;
    act_t      act_q;

    mle_snoop_decode #(.SRC_W(SRC_W), .CORE_ID(CORE_ID)) u_snoop (
        .bus_valid (bus_valid),
        .bus_cmd   (bus_cmd),
        .bus_src   (bus_src),
        .snoop     (snoop)
    );

    mle_core_gate u_gate (
        .core_valid (core_valid),
        .core_op    (core_op),
        .state      (state_q),
        .bus_valid  (bus_valid),
        .rsp_valid  (rsp_valid),
        .core_ready (core_ready),
        .req        (creq)
    );

    mle_fsm_next u_next (
        .state     (state_q),
        .req       (creq),
        .snoop     (snoop),
        .rsp_valid (rsp_valid),
        .rsp_excl  (rsp_excl),
        .nxt       (state_d),
        .act       (act_d)
    );

    // Register the line state and the action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_I;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        line_state    = state_q;
        req_valid     = act_q.req_v;
        req_cmd       = act_q.req_cmd;
        send_data     = act_q.data;
        send_nodata   = act_q.nodata;
        send_nodata_e = act_q.nodata_e;
        core_done     = act_q.done;
    end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
// Temporal checks on the port behaviour of mesi_line_ctrl, bound to each instance.
module mesi_line_ctrl_chk #(
    parameter int SRC_W   = 2,
    parameter int CORE_ID = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_valid,
    input logic [1:0]       core_op,
    input logic             core_ready,
    input logic             core_done,
    input logic             bus_valid,
    input logic [1:0]       bus_cmd,
    input logic [SRC_W-1:0] bus_src,
    input logic             rsp_valid,
    input logic             rsp_excl,
    input logic             req_valid,
    input logic [1:0]       req_cmd,
    input logic             send_data,
    input logic             send_nodata,
    input logic             send_nodata_e,
    input logic [3:0]       line_state
);
    localparam logic [SRC_W-1:0] ME = SRC_W'(CORE_ID);

    logic own_putm;
    logic take;

    // Reference event decodes for the checks.
    always_comb begin
        own_putm = bus_valid && bus_cmd == 2'd2 && bus_src == ME;
        take     = core_valid && core_ready;
    end

    a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd2 && take && core_op == 2'd1)
        |=> (line_state == 4'd3 && core_done && !req_valid));

    a_r2_excl_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd5 && rsp_valid && rsp_excl)
        |=> (line_state == 4'd2 && core_done));

    a_r4_evict_req: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd2 && take && core_op == 2'd2)
        |=> (req_valid && req_cmd == 2'd2 && line_state == 4'd11));

    a_r4_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd11 && own_putm)
        |=> (send_nodata_e && !send_data && line_state == 4'd0));

    a_r7_silent_s_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd1 && take && core_op == 2'd2)
        |=> (!req_valid && line_state == 4'd0));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state >= 4'd4 || bus_valid || rsp_valid) |-> !core_ready);

    a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_data, send_nodata, send_nodata_e}));

    a_r5_dirty_end: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 4'd10 && own_putm)
        |=> (send_data && line_state == 4'd0));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.SRC_W(SRC_W), .CORE_ID(CORE_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_valid    (core_valid),
    .core_op       (core_op),
    .core_ready    (core_ready),
    .core_done     (core_done),
    .bus_valid     (bus_valid),
    .bus_cmd       (bus_cmd),
    .bus_src       (bus_src),
    .rsp_valid     (rsp_valid),
    .rsp_excl      (rsp_excl),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .send_data     (send_data),
    .send_nodata   (send_nodata),
    .send_nodata_e (send_nodata_e),
    .line_state    (line_state)
);

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_valid = 1'b0;
    logic [1:0] core_op = '0;
    logic core_ready, core_done;
    logic bus_valid = 1'b0;
    logic [1:0] bus_cmd = '0;
    logic [SRC_W-1:0] bus_src = '0;
    logic rsp_valid = 1'b0;
    logic rsp_excl = 1'b0;
    logic req_valid;
    logic [1:0] req_cmd;
    logic send_data, send_nodata, send_nodata_e;
    logic [3:0] line_state;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_line_ctrl #(.SRC_W(SRC_W), .CORE_ID(0)) i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
        .core_ready(core_ready), .core_done(core_done), .bus_valid(bus_valid),
        .bus_cmd(bus_cmd), .bus_src(bus_src), .rsp_valid(rsp_valid),
        .rsp_excl(rsp_excl), .req_valid(req_valid), .req_cmd(req_cmd),
        .send_data(send_data), .send_nodata(send_nodata),
        .send_nodata_e(send_nodata_e), .line_state(line_state)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        core_valid = 1'b0; bus_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    task automatic core(logic [1:0] op);
        core_valid = 1'b1; core_op = op; tick();
    endtask

    task automatic bus(logic [1:0] cmd, logic [SRC_W-1:0] src);
        bus_valid = 1'b1; bus_cmd = cmd; bus_src = src; tick();
    endtask

    task automatic rsp(logic ex);
        rsp_valid = 1'b1; rsp_excl = ex; tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    // Reach a stable state (1 S, 2 E, 3 M) through real requests.
    task automatic go(int s);
        do_reset();
        if (s == 3) begin
            core(2'd1); bus(2'd1, 0); rsp(1'b0);
        end else if (s == 1 || s == 2) begin
            core(2'd0); bus(2'd0, 0); rsp(s == 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1;
        do_reset();
        // R1 reset state
        check("R1 state", line_state, 0);
        check("R1 outputs", {req_valid, core_done, send_data, send_nodata, send_nodata_e}, 0);

        // R2 plain and exclusive fills
        for (int ex = 0; ex < 2; ex++) begin
            do_reset();
            core(2'd0);
            check("R2 req", {req_valid, req_cmd}, 4);
            check("R2 is_ad", line_state, 4);
            bus(2'd0, 0);
            check("R2 is_d", line_state, 5);
            // R9 stalled request in transient
            core_valid = 1'b1; core_op = 2'd1; #1;
            check("R9 ready transient", core_ready, 0);
            tick();
            check("R9 no effect", {req_valid, 4'(line_state)}, 5);
            rsp(ex[0]);
            check("R2 fill state", line_state, ex == 1 ? 2 : 1);
            check("R2 done", core_done, 1);
        end

        // R6 R7 foreign snoops in every stable state from every foreign source
        for (int s = 1; s < 4; s++) begin
            for (int ev = 0; ev < 3; ev++) begin
                for (int src = 1; src < 4; src++) begin
                    int exp_st;
                    int exp_d;
                    go(s);
                    bus(ev[1:0], src[SRC_W-1:0]);
                    if (s == 1) begin
                        exp_st = (ev == 1) ? 0 : 1; exp_d = 0;
                    end else begin
                        exp_st = (ev == 0) ? 1 : (ev == 1) ? 0 : s;
                        exp_d = (ev != 2) ? 1 : 0;
                    end
                    check(s == 1 ? "R7 snoop state" : "R6 snoop state", line_state, exp_st);
                    check(s == 1 ? "R7 snoop data" : "R6 snoop data", send_data, exp_d);
                end
            end
        end

        // R11 hits
        for (int s = 1; s < 4; s++) begin
            go(s);
            core(2'd0);
            check("R11 load hit", {core_done, req_valid, 4'(line_state)}, 32 + s);
        end
        go(3);
        core(2'd1);
        check("R11 store hit M", {core_done, req_valid, 4'(line_state)}, 32 + 3);

        // R3 silent upgrade
        go(2);
        core(2'd1);
        check("R3 upgrade", {core_done, req_valid, 4'(line_state)}, 32 + 3);

        // R4 clean eviction
        go(2);
        core(2'd2);
        check("R4 putm", {req_valid, req_cmd}, 6);
        check("R4 ei_a", line_state, 11);
        bus(2'd2, 0);
        check("R4 nodata_e", {send_nodata_e, send_data, send_nodata}, 4);
        check("R4 to I", line_state, 0);

        // R5 dirty eviction
        go(3);
        core(2'd2);
        check("R5 putm", {req_valid, req_cmd, 4'(line_state)}, 96 + 10);
        bus(2'd2, 0);
        check("R5 data", {send_data, send_nodata_e, 4'(line_state)}, 32);

        // R7 silent S eviction
        go(1);
        core(2'd2);
        check("R7 evict", {req_valid, 4'(line_state)}, 0);

        // R8 store from S and I
        go(1);
        core(2'd1);
        check("R8 S getm", {req_valid, req_cmd, 4'(line_state)}, 80 + 8);
        bus(2'd1, 0);
        check("R8 sm_d", {core_done, 4'(line_state)}, 9);
        rsp(1'b0);
        check("R8 S done", {core_done, 4'(line_state)}, 16 + 3);
        do_reset();
        core(2'd1);
        check("R8 I getm", {req_valid, req_cmd, 4'(line_state)}, 80 + 6);
        bus(2'd1, 0);
        check("R8 im_d", {core_done, 4'(line_state)}, 7);
        rsp(1'b1);
        check("R8 I done", {core_done, 4'(line_state)}, 16 + 3);

        // R12 lost race in SM_AD
        go(1);
        core(2'd1);
        bus(2'd1, 2);
        check("R12 im_ad", line_state, 6);
        bus(2'd1, 0);
        check("R12 im_d", line_state, 7);
        rsp(1'b0);
        check("R12 done", {core_done, 4'(line_state)}, 16 + 3);

        // R10 snoop during eviction
        go(3);
        core(2'd2);
        bus(2'd0, 1);
        check("R10 MI data", {send_data, 4'(line_state)}, 16 + 12);
        bus(2'd2, 0);
        check("R10 nodata", {send_nodata, send_data, send_nodata_e, 4'(line_state)}, 64);
        go(2);
        core(2'd2);
        bus(2'd1, 3);
        check("R10 EI data", {send_data, 4'(line_state)}, 16 + 12);
        bus(2'd2, 0);
        check("R10 nodata E", {send_nodata, send_nodata_e, 4'(line_state)}, 32);

        // R9 stall during a bus cycle in a stable state
        go(1);
        core_valid = 1'b1; core_op = 2'd1;
        bus_valid = 1'b1; bus_cmd = 2'd2; bus_src = 1; #1;
        check("R9 ready bus", core_ready, 0);
        tick();
        check("R9 bus no effect", {req_valid, 4'(line_state)}, 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule